// File: doc/BRIEF.md
# Real-Time Clock with Alarms and Countdowns

This block keeps wall time as a seconds counter and a milliseconds counter, both driven by a slow-clock tick. The tick arrives as a single-cycle enable, `tick_en`, in the fast clock domain. A fractional accumulator turns the ticks into milliseconds. A second phase counter marks a copy boundary every `COPY_TICKS` ticks. Only at a copy boundary does the bus-side view of the counters move. Only at a copy boundary do writes to the counters, alarms and countdowns take effect.

Software talks to the block through a simple word read/write port. Software should wait for the busy bit to drop before it trusts a value it has just written. Reading the milliseconds register freezes the seconds view into a shadow register, so a later read gives a matching pair. Five event sources share one interrupt line:

- two seconds-match alarms
- one milliseconds-match alarm
- a seconds countdown
- a milliseconds countdown

Each source has a sticky status bit and a mask bit.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset every readable register reads 0, the busy bit (offset 0x004, bit 0) reads 0 and `irq` is 0.
- R2: The milliseconds counter advances once every `TICKS_PER_MS` ticks. It wraps from `MS_PER_SEC`-1 to 0, and that wrap increments the seconds counter by one.
- R3: The seconds view (0x008) and the milliseconds view (0x010) change only at a copy boundary. A copy boundary is the tick on which the phase counter, which counts `COPY_TICKS` ticks, is at its last value. At that boundary each view takes the counter value that results from that tick.
- R4: Busy bit 0 of 0x004 reads 1 in two cases, and reads 0 otherwise:
  - while the phase counter is at its last value;
  - while any staged write is still waiting for a boundary.
- R5: Writes to these offsets are staged and take effect at the next copy boundary:
  - 0x008 seconds
  - 0x010 milliseconds
  - 0x014 and 0x018 seconds alarms
  - 0x01C milliseconds alarm
  - 0x020 and 0x024 countdowns

  A write made on a boundary cycle waits for the following boundary. Of several writes to one register, the last one wins. A staged counter value replaces that tick's increment. A milliseconds value of `MS_PER_SEC` or more is loaded as 0.
- R6: A read strobe at offset 0x010 copies the current seconds view into the shadow register at offset 0x00C on that clock edge.
- R7: Three alarms set status bits:
  - status bit 0 is set when an increment brings the seconds counter to the value at 0x014;
  - status bit 1 is set when an increment brings the seconds counter to the value at 0x018;
  - status bit 2 is set when the milliseconds counter steps to the value at 0x01C.
- R8: Countdown registers hold an enable in bit 31 and a load value in bits 27:0; they read back as {enable, 3'b000, remaining}.
  - 0x020 steps on each seconds increment and reports on status bit 3.
  - 0x024 steps on each millisecond and reports on status bit 4.
  - On a step with 1 or 0 remaining, the countdown sets its status bit once, clears its enable and leaves 0.
  - Writing 0 disables the countdown.
- R9: Status (0x02C) bits set on their event regardless of mask. Writing 1 clears a bit and writing 0 leaves it. An event in the same cycle as a clear leaves the bit set.
- R10: A write to the mask (0x028, bits 4:0) takes effect on the next edge. `irq` equals the OR over bits of status AND mask.
- R11: Writes to 0x004, 0x00C or any unmapped offset change nothing. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per slow-clock tick |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect at 0x010 only) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational from state |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with `TICKS_PER_MS`=4, `COPY_TICKS`=8 and `MS_PER_SEC`=10. One second is then 40 ticks, so seconds wraps, seconds alarms and the seconds countdown are all reached within a few hundred cycles. Because a millisecond is shorter than a copy window, millisecond steps fall both on and between copy boundaries. That exercises overrides that coincide with an increment, and views that skip values. The tick pattern switches between every cycle, every third cycle and pseudo-random, so boundaries land at varied distances from bus writes.

// File: rtl/rtc_pkg.sv
// Shared constants for the real-time clock: register offsets, interrupt
// bit positions and the order of staged (boundary-applied) registers.
// Assumes byte offsets fit in 8 bits.
package rtc_pkg;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFS_BUSY   = 8'h04;
    localparam logic [7:0] OFS_SEC    = 8'h08;
    localparam logic [7:0] OFS_SHADOW = 8'h0C;
    localparam logic [7:0] OFS_MS     = 8'h10;
    localparam logic [7:0] OFS_SALM0  = 8'h14;
    localparam logic [7:0] OFS_SALM1  = 8'h18;
    localparam logic [7:0] OFS_MALM   = 8'h1C;
    localparam logic [7:0] OFS_SCDN   = 8'h20;
    localparam logic [7:0] OFS_MCDN   = 8'h24;
    localparam logic [7:0] OFS_MASK   = 8'h28;
    localparam logic [7:0] OFS_STAT   = 8'h2C;

    // interrupt bit positions, shared by mask and status
    localparam int IRQ_SALM0 = 0;
    localparam int IRQ_SALM1 = 1;
    localparam int IRQ_MALM  = 2;
    localparam int IRQ_SCDN  = 3;
    localparam int IRQ_MCDN  = 4;
    localparam int IRQ_W     = 5;

    // staged register slots
    localparam int STG_SEC   = 0;
    localparam int STG_MS    = 1;
    localparam int STG_SALM0 = 2;
    localparam int STG_SALM1 = 3;
    localparam int STG_MALM  = 4;
    localparam int STG_SCDN  = 5;
    localparam int STG_MCDN  = 6;
    localparam int STG_N     = 7;

    localparam int CDN_EN_BIT = 31;
    localparam int CDN_LOAD_W = 28;
    localparam int CDN_N      = 2;

    // Byte offset that feeds a given staged slot.
    function automatic logic [7:0] stage_offset(input int idx);
        case (idx)
            STG_SEC:   return OFS_SEC;
            STG_MS:    return OFS_MS;
            STG_SALM0: return OFS_SALM0;
            STG_SALM1: return OFS_SALM1;
            STG_MALM:  return OFS_MALM;
            STG_SCDN:  return OFS_SCDN;
            default:   return OFS_MCDN;
        endcase
    endfunction
endpackage

// File: rtl/rtc_timebase.sv
// Turns slow-clock tick enables into a millisecond step and a copy
// boundary strobe. Assumes tick_en is a single-cycle pulse in clk domain.
module rtc_timebase #(
    parameter int TICKS_PER_MS = 32,
    parameter int COPY_TICKS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic ms_step,
    output logic copy_evt,
    output logic copy_phase
);
    localparam int ACC_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam int CPH_W = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
    localparam logic [ACC_W-1:0] ACC_LAST = ACC_W'(TICKS_PER_MS - 1);
    localparam logic [CPH_W-1:0] CPH_LAST = CPH_W'(COPY_TICKS - 1);

    logic [ACC_W-1:0] acc_q;
    logic [CPH_W-1:0] cph_q;

    assign ms_step    = tick_en && (acc_q == ACC_LAST);
    assign copy_phase = (cph_q == CPH_LAST);
    assign copy_evt   = tick_en && copy_phase;

    // fractional tick-to-millisecond accumulator
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (ms_step) acc_q <= '0;
        else if (tick_en) acc_q <= acc_q + 1'b1;
    end

    // copy-window phase counter
    always_ff @(posedge clk) begin
        if (!rst_n)        cph_q <= '0;
        else if (copy_evt) cph_q <= '0;
        else if (tick_en)  cph_q <= cph_q + 1'b1;
    end
endmodule

// File: rtl/rtc_counters.sv
// Seconds and milliseconds counters, their bus-side views and the three
// match alarms. Loads come pre-qualified with a copy boundary.
module rtc_counters #(
    parameter int MS_PER_SEC = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ms_step,
    input  logic        copy_evt,
    input  logic        ld_sec,
    input  logic [31:0] ld_sec_val,
    input  logic        ld_ms,
    input  logic [31:0] ld_ms_val,
    input  logic [31:0] alm_sec0,
    input  logic [31:0] alm_sec1,
    input  logic [31:0] alm_ms,
    output logic [31:0] ms_cnt,
    output logic [31:0] sec_view,
    output logic [31:0] ms_view,
    output logic        sec_step,
    output logic        evt_salm0,
    output logic        evt_salm1,
    output logic        evt_malm
);
    localparam logic [31:0] MS_LAST = 32'(MS_PER_SEC - 1);
    localparam logic [31:0] MS_LIM  = 32'(MS_PER_SEC);

    logic [31:0] sec_q, ms_q;
    logic [31:0] ms_inc, sec_inc, ms_nx, sec_nx;

    assign ms_cnt = ms_q;

    // increment values and override selection for this cycle
    always_comb begin
        sec_step = ms_step && (ms_q == MS_LAST);
        ms_inc   = sec_step ? 32'd0 : ms_q + 32'd1;
        sec_inc  = sec_q + 32'd1;
        ms_nx    = ms_step ? ms_inc : ms_q;
        sec_nx   = sec_step ? sec_inc : sec_q;
        if (ld_ms)  ms_nx  = (ld_ms_val < MS_LIM) ? ld_ms_val : 32'd0;
        if (ld_sec) sec_nx = ld_sec_val;
    end

    assign evt_malm  = ms_step && (ms_inc == alm_ms);
    assign evt_salm0 = sec_step && (sec_inc == alm_sec0);
    assign evt_salm1 = sec_step && (sec_inc == alm_sec1);

    // live counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            ms_q  <= '0;
        end else begin
            sec_q <= sec_nx;
            ms_q  <= ms_nx;
        end
    end

    // bus-side views refreshed only on a copy boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_view <= '0;
            ms_view  <= '0;
        end else if (copy_evt) begin
            sec_view <= sec_nx;
            ms_view  <= ms_nx;
        end
    end
endmodule

// File: rtl/rtc_countdown.sv
// One self-disarming countdown: loaded with {enable, count}, steps down
// on each qualified step and fires once when it runs out.
module rtc_countdown
    import rtc_pkg::*;
#(
    parameter int LOAD_W = CDN_LOAD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [31:0]       load_val,
    input  logic              step,
    output logic              en,
    output logic [LOAD_W-1:0] remain,
    output logic              fire
);
    logic run_out;

    assign run_out = (remain <= LOAD_W'(1));
    assign fire    = en && step && !load && run_out;

    // load, decrement and self-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            remain <= '0;
        end else if (load) begin
            en     <= load_val[CDN_EN_BIT];
            remain <= load_val[LOAD_W-1:0];
        end else if (en && step) begin
            if (run_out) begin
                en     <= 1'b0;
                remain <= '0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
// Real-time clock top: register decode, write staging until the copy
// boundary, shadow capture, mask/status and combined interrupt.
// Assumes ADDR_W >= 8 and a synchronous tick enable.
module rtc_alarm_unit
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_MS = 32,
    parameter int COPY_TICKS   = 8,
    parameter int MS_PER_SEC   = 1000,
    parameter int ADDR_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic ms_step, copy_evt, copy_phase, sec_step;
    logic [31:0] sec_view, ms_view, ms_cnt, shadow_q;
    logic [31:0] alm_sec0_q, alm_sec1_q, alm_ms_q;
    logic [31:0] stage_val [STG_N];
    logic [STG_N-1:0] stage_pend, stage_hit;
    logic stg_wr, busy;
    logic evt_salm0, evt_salm1, evt_malm;
    logic [CDN_N-1:0] cdn_en, cdn_fire;
    logic [CDN_LOAD_W-1:0] cdn_remain [CDN_N];
    logic [IRQ_W-1:0] mask_q, status_q, evt_vec, clr_vec;
    logic wr_mask, wr_stat, rd_ms;

    rtc_timebase #(.TICKS_PER_MS(TICKS_PER_MS), .COPY_TICKS(COPY_TICKS)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .ms_step(ms_step), .copy_evt(copy_evt), .copy_phase(copy_phase)
    );

    // staging slots, one per boundary-applied register
    for (genvar s = 0; s < STG_N; s++) begin : g_stage
        assign stage_hit[s] = bus_wr && (bus_addr == ADDR_W'(stage_offset(s)));
        // capture write, hold until the next boundary consumes it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_val[s]  <= '0;
                stage_pend[s] <= 1'b0;
            end else if (stage_hit[s]) begin
                stage_val[s]  <= bus_wdata;
                stage_pend[s] <= 1'b1;
            end else if (copy_evt) begin
                stage_pend[s] <= 1'b0;
            end
        end
    end

    assign stg_wr = |stage_hit;
    assign busy   = copy_phase || (|stage_pend);

    rtc_counters #(.MS_PER_SEC(MS_PER_SEC)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ms_step(ms_step), .copy_evt(copy_evt),
        .ld_sec(copy_evt && stage_pend[STG_SEC]), .ld_sec_val(stage_val[STG_SEC]),
        .ld_ms(copy_evt && stage_pend[STG_MS]), .ld_ms_val(stage_val[STG_MS]),
        .alm_sec0(alm_sec0_q), .alm_sec1(alm_sec1_q), .alm_ms(alm_ms_q),
        .ms_cnt(ms_cnt), .sec_view(sec_view), .ms_view(ms_view),
        .sec_step(sec_step), .evt_salm0(evt_salm0), .evt_salm1(evt_salm1),
        .evt_malm(evt_malm)
    );

    // alarm thresholds applied on the boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_sec0_q <= '0;
            alm_sec1_q <= '0;
            alm_ms_q   <= '0;
        end else if (copy_evt) begin
            if (stage_pend[STG_SALM0]) alm_sec0_q <= stage_val[STG_SALM0];
            if (stage_pend[STG_SALM1]) alm_sec1_q <= stage_val[STG_SALM1];
            if (stage_pend[STG_MALM])  alm_ms_q   <= stage_val[STG_MALM];
        end
    end

    // countdowns: slot 0 steps on seconds, slot 1 on milliseconds
    for (genvar c = 0; c < CDN_N; c++) begin : g_cdn
        logic step_c;
        assign step_c = (c == 0) ? sec_step : ms_step;
        rtc_countdown u_cd (
            .clk(clk), .rst_n(rst_n),
            .load(copy_evt && stage_pend[STG_SCDN + c]),
            .load_val(stage_val[STG_SCDN + c]),
            .step(step_c), .en(cdn_en[c]), .remain(cdn_remain[c]),
            .fire(cdn_fire[c])
        );
    end

    assign wr_mask = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign rd_ms   = bus_rd && (bus_addr == ADDR_W'(OFS_MS));

    always_comb begin
        evt_vec            = '0;
        evt_vec[IRQ_SALM0] = evt_salm0;
        evt_vec[IRQ_SALM1] = evt_salm1;
        evt_vec[IRQ_MALM]  = evt_malm;
        evt_vec[IRQ_SCDN]  = cdn_fire[0];
        evt_vec[IRQ_MCDN]  = cdn_fire[1];
        clr_vec            = wr_stat ? bus_wdata[IRQ_W-1:0] : '0;
    end

    // sticky status with write-one-to-clear, events win
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | evt_vec;
    end

    // interrupt mask, written immediately
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= bus_wdata[IRQ_W-1:0];
    end

    // shadow seconds captured by a milliseconds read
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_q <= '0;
        else if (rd_ms) shadow_q <= sec_view;
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_BUSY):   bus_rdata = {31'd0, busy};
            ADDR_W'(OFS_SEC):    bus_rdata = sec_view;
            ADDR_W'(OFS_SHADOW): bus_rdata = shadow_q;
            ADDR_W'(OFS_MS):     bus_rdata = ms_view;
            ADDR_W'(OFS_SALM0):  bus_rdata = alm_sec0_q;
            ADDR_W'(OFS_SALM1):  bus_rdata = alm_sec1_q;
            ADDR_W'(OFS_MALM):   bus_rdata = alm_ms_q;
            ADDR_W'(OFS_SCDN):   bus_rdata = {cdn_en[0], 3'd0, cdn_remain[0]};
            ADDR_W'(OFS_MCDN):   bus_rdata = {cdn_en[1], 3'd0, cdn_remain[1]};
            ADDR_W'(OFS_MASK):   bus_rdata = {27'd0, mask_q};
            ADDR_W'(OFS_STAT):   bus_rdata = {27'd0, status_q};
            default:             bus_rdata = '0;
        endcase
    end

    assign irq = |(status_q & mask_q);
endmodule

// Checker for rtc_alarm_unit, attached by bind below.
module rtc_alarm_chk
    import rtc_pkg::*;
#(
    parameter int MS_PER_SEC = 1000,
    parameter int ADDR_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              copy_evt,
    input logic              stg_wr,
    input logic              busy,
    input logic [STG_N-1:0]  stage_pend,
    input logic [31:0]       sec_view,
    input logic [31:0]       ms_view,
    input logic [31:0]       ms_cnt,
    input logic [31:0]       shadow_q,
    input logic [IRQ_W-1:0]  mask_q,
    input logic [IRQ_W-1:0]  status_q,
    input logic [CDN_N-1:0]  cdn_en,
    input logic [CDN_N-1:0]  cdn_fire,
    input logic              irq
);
    AST_MS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ms_cnt < 32'(MS_PER_SEC)); // R2
    AST_VIEW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !copy_evt |=> ($stable(sec_view) && $stable(ms_view))); // R3
    AST_BUSY_AFTER_STAGE: assert property (@(posedge clk) disable iff (!rst_n) stg_wr |=> busy); // R4
    AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n) (copy_evt && !stg_wr) |=> (stage_pend == '0)); // R5
    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && bus_addr == ADDR_W'(OFS_MS)) |=> (shadow_q == $past(sec_view))); // R6
    AST_SEC_CDN_DISARM: assert property (@(posedge clk) disable iff (!rst_n) cdn_fire[0] |=> !cdn_en[0]); // R8
    AST_MS_CDN_DISARM: assert property (@(posedge clk) disable iff (!rst_n) cdn_fire[1] |=> !cdn_en[1]); // R8
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !(bus_wr && bus_addr == ADDR_W'(OFS_STAT)) |=> ((status_q & $past(status_q)) == $past(status_q))); // R9
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (mask_q != '0)); // R10
endmodule

bind rtc_alarm_unit rtc_alarm_chk #(.MS_PER_SEC(MS_PER_SEC), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .copy_evt(copy_evt), .stg_wr(stg_wr), .busy(busy), .stage_pend(stage_pend),
    .sec_view(sec_view), .ms_view(ms_view), .ms_cnt(ms_cnt), .shadow_q(shadow_q),
    .mask_q(mask_q), .status_q(status_q), .cdn_en(cdn_en), .cdn_fire(cdn_fire),
    .irq(irq)
);

// File: tb/rtc_alarm_unit_tb.sv
// Bench: behavioural reference model compared with the ports every clock.
module rtc_alarm_unit_tb;
    localparam int TPM = 4;
    localparam int CPY = 8;
    localparam int MPS = 10;

    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq;

    int checks = 0, fails = 0;
    bit done = 0;
    int tick_mode = 0;

    always #10 clk = ~clk;

    rtc_alarm_unit #(.TICKS_PER_MS(TPM), .COPY_TICKS(CPY), .MS_PER_SEC(MPS), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference model state
    int m_acc, m_cph;
    logic [31:0] m_ms, m_sec, m_msv, m_secv, m_shadow, m_sa0, m_sa1, m_ma;
    logic [31:0] m_stg [7];
    bit m_pend [7];
    bit m_cen [2];
    logic [31:0] m_ccnt [2];
    logic [4:0] m_mask, m_stat;

    function automatic int stage_of(input logic [7:0] a);
        case (a)
            8'h08: return 0;
            8'h10: return 1;
            8'h14: return 2;
            8'h18: return 3;
            8'h1C: return 4;
            8'h20: return 5;
            8'h24: return 6;
            default: return -1;
        endcase
    endfunction

    function automatic bit m_busy();
        bit b = (m_cph == CPY - 1);
        for (int i = 0; i < 7; i++) b = b | m_pend[i];
        return b;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h04: return {31'd0, m_busy()};
            8'h08: return m_secv;
            8'h0C: return m_shadow;
            8'h10: return m_msv;
            8'h14: return m_sa0;
            8'h18: return m_sa1;
            8'h1C: return m_ma;
            8'h20: return {m_cen[0], 3'd0, m_ccnt[0][27:0]};
            8'h24: return {m_cen[1], 3'd0, m_ccnt[1][27:0]};
            8'h28: return {27'd0, m_mask};
            8'h2C: return {27'd0, m_stat};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        case (a)
            8'h04: return "R4";
            8'h08, 8'h10: return "R3/R2/R5";
            8'h0C: return "R6";
            8'h14, 8'h18, 8'h1C: return "R7";
            8'h20, 8'h24: return "R8";
            8'h28: return "R10";
            8'h2C: return "R9";
            default: return "R11";
        endcase
    endfunction

    // model update on each rising edge
    always @(posedge clk) begin : model
        logic [4:0] ev;
        logic [31:0] nms, nsec, old_secv;
        bit ms_step, copy, sec_step, st;
        int s;
        if (!rst_n) begin
            m_acc = 0; m_cph = 0; m_ms = 0; m_sec = 0; m_msv = 0; m_secv = 0;
            m_shadow = 0; m_sa0 = 0; m_sa1 = 0; m_ma = 0; m_mask = 0; m_stat = 0;
            for (int i = 0; i < 7; i++) begin m_stg[i] = 0; m_pend[i] = 0; end
            for (int i = 0; i < 2; i++) begin m_cen[i] = 0; m_ccnt[i] = 0; end
        end else begin
            ev = 0; old_secv = m_secv; ms_step = 0; copy = 0; sec_step = 0;
            if (tick_en) begin
                ms_step = (m_acc == TPM - 1);
                m_acc = ms_step ? 0 : m_acc + 1;
                copy = (m_cph == CPY - 1);
                m_cph = copy ? 0 : m_cph + 1;
            end
            nms = m_ms; nsec = m_sec;
            if (ms_step) begin
                if (m_ms == MPS - 1) begin nms = 0; nsec = m_sec + 1; sec_step = 1; end
                else nms = m_ms + 1;
                if (nms == m_ma) ev[2] = 1;
                if (sec_step && nsec == m_sa0) ev[0] = 1;
                if (sec_step && nsec == m_sa1) ev[1] = 1;
            end
            for (int c = 0; c < 2; c++) begin
                st = (c == 0) ? sec_step : ms_step;
                if (copy && m_pend[5 + c]) begin
                    m_cen[c] = m_stg[5 + c][31];
                    m_ccnt[c] = m_stg[5 + c] & 32'h0FFF_FFFF;
                end else if (m_cen[c] && st) begin
                    if (m_ccnt[c] <= 1) begin ev[3 + c] = 1; m_cen[c] = 0; m_ccnt[c] = 0; end
                    else m_ccnt[c] = m_ccnt[c] - 1;
                end
            end
            if (copy && m_pend[0]) nsec = m_stg[0];
            if (copy && m_pend[1]) nms = (m_stg[1] < MPS) ? m_stg[1] : 0;
            m_ms = nms; m_sec = nsec;
            if (copy) begin
                m_msv = m_ms; m_secv = m_sec;
                if (m_pend[2]) m_sa0 = m_stg[2];
                if (m_pend[3]) m_sa1 = m_stg[3];
                if (m_pend[4]) m_ma = m_stg[4];
                for (int i = 0; i < 7; i++) m_pend[i] = 0;
            end
            if (bus_rd && bus_addr == 8'h10) m_shadow = old_secv;
            if (bus_wr) begin
                s = stage_of(bus_addr);
                if (s >= 0) begin m_stg[s] = bus_wdata; m_pend[s] = 1; end
                if (bus_addr == 8'h28) m_mask = bus_wdata[4:0];
                if (bus_addr == 8'h2C) m_stat = m_stat & ~bus_wdata[4:0];
            end
            m_stat = m_stat | ev;
        end
    end

    // comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (bus_rdata !== m_read(bus_addr)) begin
                fails++;
                $display("FAIL %s addr=%h actual=%h expected=%h", req_of(bus_addr), bus_addr, bus_rdata, m_read(bus_addr));
            end
            checks++;
            if (irq !== |(m_stat & m_mask)) begin
                fails++;
                $display("FAIL R10 irq actual=%0b expected=%0b", irq, |(m_stat & m_mask));
            end
        end
    end

    // tick generator: every cycle, every third cycle, or pseudo-random
    logic [15:0] lfsr = 16'hACE1;
    int tcnt = 0;
    always @(posedge clk) begin
        #2;
        tcnt++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (tick_mode)
            0: tick_en = 1'b1;
            1: tick_en = (tcnt % 3 == 0);
            default: tick_en = lfsr[0];
        endcase
    end

    logic [7:0] probe [12] = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                               8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30};

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2;
            bus_wr = 0; bus_rd = 1; bus_addr = probe[k % 12];
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        bus_wr = 0; bus_rd = 1; bus_addr = a;
        #8;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        // R1: reset state
        rd_check(8'h04, 32'd0, "R1");
        rd_check(8'h2C, 32'd0, "R1");
        rd_check(8'h08, 32'd0, "R1");
        checks++;
        if (irq !== 1'b0) begin
            fails++;
            $display("FAIL R1 irq actual=%0b expected=0", irq);
        end
        // R2, R3: free run across several second wraps
        idle(300);
        // R7, R10: alarms armed with the mask open
        wr(8'h28, 32'h1F);
        wr(8'h14, 32'd12);
        wr(8'h18, 32'd14);
        wr(8'h1C, 32'd7);
        idle(500);
        // R9: a zero write leaves status, then W1C
        wr(8'h2C, 32'h0);
        idle(3);
        wr(8'h2C, 32'h1);
        idle(3);
        wr(8'h2C, 32'h1F);
        idle(20);
        // R8: countdowns, slower ticks
        tick_mode = 1;
        wr(8'h24, 32'h8000_0005);
        idle(150);
        wr(8'h20, 32'h8000_0001);
        idle(400);
        wr(8'h24, 32'h8000_0000);
        idle(60);
        wr(8'h24, 32'h8000_0009);
        wr(8'h24, 32'h0000_0000);
        idle(200);
        // R5: staged counter writes, seconds wrap and out-of-range milliseconds
        wr(8'h08, 32'hFFFF_FFFE);
        idle(300);
        wr(8'h10, 32'd3);
        idle(40);
        wr(8'h10, 32'd25);
        idle(40);
        // R11: writes to read-only and unmapped offsets
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h1234_5678);
        wr(8'h30, 32'hDEAD_BEEF);
        rd_check(8'h30, 32'd0, "R11");
        rd_check(8'h3C, 32'd0, "R11");
        // R6: shadow read after milliseconds read (model comparison)
        idle(24);
        // R4: busy under random ticks with mixed traffic
        tick_mode = 2;
        wr(8'h28, 32'h04);
        wr(8'h1C, 32'd2);
        idle(600);
        wr(8'h2C, 32'h1F);
        wr(8'h28, 32'h00);
        idle(200);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule